// File: doc/BRIEF.md
# Synchronized Clock Stop Gate

This block derives two groups of clock outputs from one fast internal reference clock and stops or restarts each group under an asynchronous active-low stop request. The first group runs at a processor rate. The second group runs at half that rate and carries one extra output that the stop request never touches. A stop only bites on a phase boundary. Outputs are always parked low. A restarted output always begins with a high phase of full width.

Each group has its own stop input. That input passes through a two-flop synchronizer in the reference domain. A per-output enable vector holds any single output low. A mode strap turns off the effect of both stop inputs, so a board that wires those pins to another purpose loses no clocks. Every change to a gate, whether it comes from a stop input or an enable bit, is loaded at the reference edge where that group's divided clock goes high. A pulse that has already started is therefore never cut, and a pulse that is allowed to begin is always complete.

Top module: `clk_stop_gate`

## Requirements
- R1: Each stop input is synchronized through two reference-clock flops. An output may begin a high phase at edge E only if, at the edge before E, the strap was 1 or the group's stop input, seen three edges earlier, was 1.
- R2: Every high phase on every output is exactly one half period long: CPU_HALF reference cycles in the CPU group, and 2*CPU_HALF in the bus group and on the free-running output.
- R3: A stopped or disabled output is held at logic 0.
- R4: A change on the CPU stop input takes effect at the first CPU rising point that comes at least three reference edges after the change. Both the turn-off latency and the turn-on latency are under 4 CPU clock cycles.
- R5: The bus stop input acts only on the bus group and leaves the CPU group alone. A change on it takes effect at the first bus rising point after synchronization, so both the turn-off latency and the turn-on latency are within one bus period plus three reference cycles.
- R6: The free-running bus output ignores both stop inputs and the strap. It is gated only by bus_free_en_i.
- R7: When strap_i is 1, both stop inputs have no effect and every output follows only its enable bit.
- R8: Bit i of cpu_en_i gates cpu_clk_o[i], and bit i of bus_en_i gates bus_clk_o[i]. A 0 holds that output low and a 1 lets it run. A change is loaded at the next rising point of the group, so a high phase already under way finishes at full width.
- R9: Both groups are phase aligned from reset. The CPU clock is high in the reference cycles where floor(k/CPU_HALF) is odd, and the bus clock is high where floor(k/(2*CPU_HALF)) is odd, with k counted in reference edges since reset release.
- R10: While rst_ni is low, all outputs are 0. The stop synchronizers reset to the stopped state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast internal reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_i | input | 1 | Mode strap. A 1 disables both stop inputs |
| cpu_stop_ni | input | 1 | Asynchronous active-low stop request for the CPU group |
| bus_stop_ni | input | 1 | Asynchronous active-low stop request for the bus group |
| cpu_en_i | input | N_CPU | Per-output enables for the CPU group |
| bus_en_i | input | N_BUS | Per-output enables for the stoppable bus outputs |
| bus_free_en_i | input | 1 | Enable for the free-running bus output |
| cpu_clk_o | output | N_CPU | Gated CPU-rate clock levels |
| bus_clk_o | output | N_BUS | Gated half-rate bus clock levels |
| bus_free_o | output | 1 | Bus clock that is never stopped |

## Verification
The bench builds the block with the default values: four CPU outputs, six bus outputs and CPU_HALF of 2. With these values a CPU period is four reference cycles and a bus period is eight. Every latency bound and pulse width can then be checked within windows of a few dozen cycles, and a full bus period can be compared sample by sample against a wave the bench computes itself. At this small half period, a stop request lands close to a rising point, which exercises the case where the synchronizer delay and the phase boundary nearly coincide.

// File: rtl/clk_stop_gate_pkg.sv
package clk_stop_gate_pkg;
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;

  function automatic int unsigned cnt_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cgs_sync.sv
module cgs_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/cgs_div.sv
module cgs_div
  import clk_stop_gate_pkg::*;
#(
  parameter int unsigned HALF = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  output phase_e phase_o,
  output logic   rise_o
);
  localparam int unsigned CW = cnt_w(HALF);

  logic [CW-1:0] cnt_q;
  phase_e        ph_q;
  logic          last;

  assign last = (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= PH_LOW;
    end else if (last) begin
      cnt_q <= '0;
      ph_q  <= (ph_q == PH_LOW) ? PH_HIGH : PH_LOW;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o = ph_q;
  // edge at which the divided clock goes high: the only point gates may change
  assign rise_o  = last && (ph_q == PH_LOW);
endmodule

// File: rtl/cgs_group.sv
module cgs_group
  import clk_stop_gate_pkg::*;
#(
  parameter int unsigned N        = 4,
  parameter int unsigned HALF     = 2,
  parameter bit          HAS_FREE = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         strap_i,
  input  logic         stop_ni,
  input  logic [N-1:0] en_i,
  input  logic         free_en_i,
  output logic [N-1:0] clk_o,
  output logic         free_o
);
  phase_e       ph;
  logic         rise;
  logic         stop_sync_n;
  logic         run;
  logic [N-1:0] gate_q;

  cgs_sync #(.RST_VAL(1'b0)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (stop_ni),
    .q_o   (stop_sync_n)
  );

  cgs_div #(.HALF(HALF)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_o(ph),
    .rise_o (rise)
  );

  assign run = strap_i | stop_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   gate_q <= '0;
    else if (rise) gate_q <= run ? en_i : '0;
  end

  assign clk_o = (ph == PH_HIGH) ? gate_q : '0;

  generate
    if (HAS_FREE) begin : g_free
      logic free_gate_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   free_gate_q <= 1'b0;
        else if (rise) free_gate_q <= free_en_i;
      end
      assign free_o = (ph == PH_HIGH) && free_gate_q;
    end else begin : g_nofree
      logic unused_free_en;
      assign unused_free_en = free_en_i;
      assign free_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
  parameter int unsigned N_CPU    = 4,
  parameter int unsigned N_BUS    = 6,
  parameter int unsigned CPU_HALF = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strap_i,
  input  logic             cpu_stop_ni,
  input  logic             bus_stop_ni,
  input  logic [N_CPU-1:0] cpu_en_i,
  input  logic [N_BUS-1:0] bus_en_i,
  input  logic             bus_free_en_i,
  output logic [N_CPU-1:0] cpu_clk_o,
  output logic [N_BUS-1:0] bus_clk_o,
  output logic             bus_free_o
);
  localparam int unsigned BUS_HALF = 2 * CPU_HALF;

  logic unused_cpu_free;

  cgs_group #(.N(N_CPU), .HALF(CPU_HALF), .HAS_FREE(1'b0)) u_cpu (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strap_i  (strap_i),
    .stop_ni  (cpu_stop_ni),
    .en_i     (cpu_en_i),
    .free_en_i(1'b0),
    .clk_o    (cpu_clk_o),
    .free_o   (unused_cpu_free)
  );

  cgs_group #(.N(N_BUS), .HALF(BUS_HALF), .HAS_FREE(1'b1)) u_bus (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strap_i  (strap_i),
    .stop_ni  (bus_stop_ni),
    .en_i     (bus_en_i),
    .free_en_i(bus_free_en_i),
    .clk_o    (bus_clk_o),
    .free_o   (bus_free_o)
  );
endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk #(
  parameter int unsigned N_CPU    = 4,
  parameter int unsigned N_BUS    = 6,
  parameter int unsigned CPU_HALF = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             strap_i,
  input logic             cpu_stop_ni,
  input logic             bus_stop_ni,
  input logic [N_CPU-1:0] cpu_en_i,
  input logic [N_BUS-1:0] bus_en_i,
  input logic             bus_free_en_i,
  input logic [N_CPU-1:0] cpu_clk_o,
  input logic [N_BUS-1:0] bus_clk_o,
  input logic             bus_free_o
);
  localparam int unsigned BUS_HALF = 2 * CPU_HALF;
  localparam int unsigned RW       = $clog2(BUS_HALF + 2) + 1;

  // high-run length counters replace parameter-deep $past windows
  generate
    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
      logic [RW-1:0] run_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           run_q <= '0;
        else if (!cpu_clk_o[i]) run_q <= '0;
        else if (run_q != '1)  run_q <= run_q + 1'b1;
      end

      assert_cpu_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(cpu_clk_o[i]) |-> run_q == RW'(CPU_HALF));
      assert_cpu_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cpu_clk_o[i]) |-> $past(cpu_en_i[i]));
      assert_cpu_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cpu_clk_o[i]) |-> ($past(strap_i) || $past(cpu_stop_ni, 3)));
    end

    for (genvar i = 0; i < N_BUS; i++) begin : g_bus
      logic [RW-1:0] run_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           run_q <= '0;
        else if (!bus_clk_o[i]) run_q <= '0;
        else if (run_q != '1)  run_q <= run_q + 1'b1;
      end

      assert_bus_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(bus_clk_o[i]) |-> run_q == RW'(BUS_HALF));
      assert_bus_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(bus_clk_o[i]) |-> $past(bus_en_i[i]));
      assert_bus_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(bus_clk_o[i]) |-> ($past(strap_i) || $past(bus_stop_ni, 3)));
      assert_bus_align_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(bus_clk_o[i]) && $past(bus_free_en_i)) |-> $rose(bus_free_o));
    end
  endgenerate

  logic [RW-1:0] free_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               free_run_q <= '0;
    else if (!bus_free_o)      free_run_q <= '0;
    else if (free_run_q != '1) free_run_q <= free_run_q + 1'b1;
  end

  assert_free_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_free_o) |-> free_run_q == RW'(BUS_HALF));
  assert_free_en_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_free_o) |-> $past(bus_free_en_i));
endmodule

bind clk_stop_gate clk_stop_gate_chk #(
  .N_CPU(N_CPU), .N_BUS(N_BUS), .CPU_HALF(CPU_HALF)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .strap_i      (strap_i),
  .cpu_stop_ni  (cpu_stop_ni),
  .bus_stop_ni  (bus_stop_ni),
  .cpu_en_i     (cpu_en_i),
  .bus_en_i     (bus_en_i),
  .bus_free_en_i(bus_free_en_i),
  .cpu_clk_o    (cpu_clk_o),
  .bus_clk_o    (bus_clk_o),
  .bus_free_o   (bus_free_o)
);

// File: tb/clk_stop_gate_tb_top.sv
module clk_stop_gate_tb_top;
  localparam int N_CPU    = 4;
  localparam int N_BUS    = 6;
  localparam int CPU_HALF = 2;
  localparam int BUS_HALF = 2 * CPU_HALF;
  localparam int NV       = 8;

  // {strap, cpu_stop_n, bus_stop_n, cpu_en[3:0], bus_en[5:0], free_en}
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b1, 4'hF, 6'h3F, 1'b1},
    {1'b0, 1'b0, 1'b1, 4'hF, 6'h3F, 1'b1},
    {1'b0, 1'b1, 1'b0, 4'hF, 6'h3F, 1'b1},
    {1'b0, 1'b0, 1'b0, 4'hF, 6'h3F, 1'b1},
    {1'b1, 1'b0, 1'b0, 4'hF, 6'h3F, 1'b1},
    {1'b0, 1'b1, 1'b1, 4'h5, 6'h2A, 1'b0},
    {1'b1, 1'b1, 1'b0, 4'hA, 6'h15, 1'b1},
    {1'b0, 1'b0, 1'b1, 4'h3, 6'h3F, 1'b0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             strap = 1'b0;
  logic             cpu_stop_n = 1'b1;
  logic             bus_stop_n = 1'b1;
  logic [N_CPU-1:0] cpu_en = '1;
  logic [N_BUS-1:0] bus_en = '1;
  logic             free_en = 1'b1;
  logic [N_CPU-1:0] cpu_clk;
  logic [N_BUS-1:0] bus_clk;
  logic             bus_free;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (rst_n) cyc <= cyc + 1;
    else       cyc <= 0;
  end

  clk_stop_gate #(.N_CPU(N_CPU), .N_BUS(N_BUS), .CPU_HALF(CPU_HALF)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .strap_i      (strap),
    .cpu_stop_ni  (cpu_stop_n),
    .bus_stop_ni  (bus_stop_n),
    .cpu_en_i     (cpu_en),
    .bus_en_i     (bus_en),
    .bus_free_en_i(free_en),
    .cpu_clk_o    (cpu_clk),
    .bus_clk_o    (bus_clk),
    .bus_free_o   (bus_free)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit cpu_hi(int k);
    return ((k / CPU_HALF) % 2) == 1;
  endfunction

  function automatic bit bus_hi(int k);
    return ((k / BUS_HALF) % 2) == 1;
  endfunction

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [N_CPU-1:0] cpu_h [24];
    logic [N_BUS-1:0] bus_h [24];
    logic             free_h [24];
    int first, width, last, cnt;

    // R10: reset state
    wait_n(3);
    chk(cpu_clk == '0 && bus_clk == '0 && bus_free == 1'b0, "R10 in reset",
        int'({cpu_clk, bus_clk, bus_free}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_clk == '0 && bus_clk == '0 && bus_free == 1'b0, "R10 after release",
        int'({cpu_clk, bus_clk, bus_free}), 0);

    // vector table: R3 R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      logic [N_CPU-1:0] cm;
      logic [N_BUS-1:0] bm;
      int ec, eb, ef;
      {strap, cpu_stop_n, bus_stop_n, cpu_en, bus_en, free_en} = VEC[v];
      cm = (strap | cpu_stop_n) ? cpu_en : '0;
      bm = (strap | bus_stop_n) ? bus_en : '0;
      wait_n(24);
      ec = 0; eb = 0; ef = 0;
      for (int j = 0; j < 2 * BUS_HALF; j++) begin
        @(negedge clk);
        if (cpu_clk != (cpu_hi(cyc) ? cm : '0)) ec++;
        if (bus_clk != (bus_hi(cyc) ? bm : '0)) eb++;
        if (bus_free != (bus_hi(cyc) && free_en)) ef++;
      end
      chk(ec == 0, "R3 R7 R8 R9 cpu wave mismatches", ec, 0);
      chk(eb == 0, "R3 R5 R7 R8 R9 bus wave mismatches", eb, 0);
      chk(ef == 0, "R6 free wave mismatches", ef, 0);
    end

    // all running
    {strap, cpu_stop_n, bus_stop_n, cpu_en, bus_en, free_en} = VEC[0];
    wait_n(24);

    // R4: CPU turn-off latency
    cpu_stop_n = 1'b0;
    last = 0;
    for (int e = 1; e <= 24; e++) begin
      @(negedge clk);
      if (cpu_clk != '0) last = e;
    end
    chk(last < 4 * 2 * CPU_HALF, "R4 cpu off latency", last, 4 * 2 * CPU_HALF - 1);

    // R4 R2: CPU turn-on latency and full first pulse
    cpu_stop_n = 1'b1;
    for (int e = 0; e < 24; e++) begin
      @(negedge clk);
      cpu_h[e] = cpu_clk;
    end
    first = -1; width = 0;
    for (int e = 0; e < 24; e++)
      if (first < 0 && cpu_h[e] != '0) first = e;
    if (first >= 0)
      for (int e = first; e < 24 && cpu_h[e] == 4'hF; e++) width++;
    chk(first >= 0 && first + 1 < 4 * 2 * CPU_HALF, "R4 cpu on latency", first + 1,
        4 * 2 * CPU_HALF - 1);
    chk(width == CPU_HALF, "R2 cpu first pulse width", width, CPU_HALF);

    // R5 R6: bus turn-off, free output keeps running
    bus_stop_n = 1'b0;
    last = 0; cnt = 0;
    for (int e = 1; e <= 24; e++) begin
      @(negedge clk);
      if (bus_clk != '0) last = e;
      if (bus_free) cnt++;
    end
    chk(last <= 2 * BUS_HALF + 3, "R5 bus off latency", last, 2 * BUS_HALF + 3);
    chk(cnt == 12, "R6 free high samples while bus stopped", cnt, 12);

    // R5 R2 R9: bus turn-on
    bus_stop_n = 1'b1;
    for (int e = 0; e < 24; e++) begin
      @(negedge clk);
      bus_h[e]  = bus_clk;
      free_h[e] = bus_free;
    end
    first = -1; width = 0;
    for (int e = 0; e < 24; e++)
      if (first < 0 && bus_h[e] != '0) first = e;
    if (first >= 0)
      for (int e = first; e < 24 && bus_h[e] == 6'h3F; e++) width++;
    chk(first >= 0 && first + 1 <= 2 * BUS_HALF + 3, "R5 bus on latency", first + 1,
        2 * BUS_HALF + 3);
    chk(width == BUS_HALF, "R2 bus first pulse width", width, BUS_HALF);
    chk(first >= 0 && free_h[first], "R9 bus restart aligned with free output",
        first >= 0 ? int'(free_h[first]) : -1, 1);

    // R8 R2: enable cleared at start of a high phase does not cut that pulse
    while (!(cyc % (2 * CPU_HALF) == CPU_HALF)) @(negedge clk);
    cpu_en = 4'hE;
    @(negedge clk);
    chk(cpu_clk[0] == 1'b1, "R2 pulse kept after enable drop", int'(cpu_clk[0]), 1);
    wait_n(8);
    cnt = 0; width = 0;
    for (int e = 0; e < 2 * BUS_HALF; e++) begin
      @(negedge clk);
      if (cpu_clk[0]) cnt++;
      if (cpu_clk[3:1] == (cpu_hi(cyc) ? 3'b111 : 3'b000)) width++;
    end
    chk(cnt == 0, "R8 disabled output high samples", cnt, 0);
    chk(width == 2 * BUS_HALF, "R8 other outputs unaffected", width, 2 * BUS_HALF);

    // R10: asynchronous reset while running
    cpu_en = '1;
    wait_n(16);
    while (!cpu_hi(cyc)) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(cpu_clk == '0 && bus_clk == '0 && bus_free == 1'b0, "R10 async reset",
        int'({cpu_clk, bus_clk, bus_free}), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule